// File: doc/BRIEF.md
# Transmit Descriptor DMA Run/Suspend Controller

This block sequences a transmit descriptor DMA. It holds the address of the current descriptor and moves between three externally visible states: stopped, running and suspended. Software drives a level start bit. A descriptor fetch unit reports whether each fetched descriptor is owned by the DMA and whether it carries an end-of-ring mark. The transmit path pulses a signal when a frame has been fully sent. The controller itself only asks for fetches and advances the pointer. Bus access, descriptor decoding and data movement belong to other blocks.

Stopping is graceful. When the start bit is cleared during a frame, the controller keeps running until that frame completes. It then records the next descriptor position, so the next start resumes from that position and not from the list base. If a fetched descriptor is not owned, the controller suspends and raises a sticky status bit. That bit is cleared by writing one. A poll-demand pulse makes the controller try the same descriptor again.

Top module: `tx_dma_ctrl`

## Requirements
- R1: After reset, state_o is 0 (stopped), fetch_req_o is 0, susp_sts_o is 0 and fetch_addr_o is 0; state_o never takes the value 3.
- R2: In the stopped state with no position saved since reset, start_i high moves the controller to running (state_o = 1) on the next cycle, with fetch_req_o high and fetch_addr_o equal to list_base_i.
- R3: When fetch_done_i arrives while a fetch is pending: if own_i is 1, the controller stays running and fetch_req_o drops on the next cycle; if own_i is 0, it enters suspended (state_o = 2) and susp_sts_o is set on the next cycle.
- R4: A frame_done_i pulse while a frame is in progress advances fetch_addr_o by DESC_BYTES (default 16) and starts a new fetch. If the descriptor of that frame had eor_i = 1 when it was fetched, fetch_addr_o wraps to list_base_i instead.
- R5: Clearing start_i while a frame is in progress keeps state_o at running until frame_done_i. On that pulse the controller goes to stopped, with fetch_addr_o at the next descriptor.
- R6: Once a position has been saved, a new start fetches from the saved position, even if list_base_i has changed.
- R7: In suspended with start_i low, the controller goes to stopped on the next cycle and keeps the pointer at the unowned descriptor. A later start fetches that same descriptor again.
- R8: In suspended with start_i high, a poll_i pulse starts a new fetch at the same pointer. If that descriptor is owned, the controller returns to running.
- R9: susp_sts_o is cleared on the cycle after susp_clr_i is high. A new suspend event in the same cycle takes priority, and the bit stays 1.
- R10: poll_i has no effect while a frame is in progress: no fetch is requested and the pointer does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start/stop command level (1 = run) |
| poll_i | input | 1 | Poll-demand pulse |
| list_base_i | input | AW | Descriptor list base address |
| fetch_done_i | input | 1 | Descriptor fetch finished |
| own_i | input | 1 | Fetched descriptor owned by DMA |
| eor_i | input | 1 | Fetched descriptor carries end-of-ring mark |
| frame_done_i | input | 1 | Current frame fully transmitted |
| susp_clr_i | input | 1 | Write-one-to-clear for suspend status |
| state_o | output | 2 | 0 stopped, 1 running, 2 suspended |
| fetch_req_o | output | 1 | Descriptor fetch request |
| fetch_addr_o | output | AW | Current descriptor address |
| susp_sts_o | output | 1 | Transmit suspended status (sticky) |

## Verification
The hardest case to reach is the set-over-clear collision on the status bit. A second unowned fetch must finish in exactly the cycle in which software writes the clear. The stimulus first suspends the controller, then issues a poll and lines up fetch_done_i with own_i low and susp_clr_i high on the same cycle. The resume-after-stop case is also set up on purpose: the list base is changed while the controller is stopped, so a start that wrongly fetches from the base shows up as a different fetch address.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    ST_STOP  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2,
    ST_SUSP  = 2'd3
  } ctl_st_e;

  localparam logic [1:0] OUT_STOPPED = 2'd0;
  localparam logic [1:0] OUT_RUNNING = 2'd1;
  localparam logic [1:0] OUT_SUSPEND = 2'd2;
endpackage

// File: rtl/tdc_fsm.sv
module tdc_fsm
  import tdc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    poll_i,
  input  logic    fetch_done_i,
  input  logic    own_i,
  input  logic    frame_done_i,
  output ctl_st_e st_o,
  output logic    load_o,
  output logic    accept_o,
  output logic    miss_o,
  output logic    adv_o,
  output logic    save_o
);
  ctl_st_e st_q, st_d;

  always_comb begin
    load_o   = (st_q == ST_STOP) && start_i;
    accept_o = (st_q == ST_FETCH) && fetch_done_i && own_i;
    miss_o   = (st_q == ST_FETCH) && fetch_done_i && !own_i;
    adv_o    = (st_q == ST_XFER) && frame_done_i;
    save_o   = (adv_o && !start_i) || ((st_q == ST_SUSP) && !start_i);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_STOP:  if (start_i) st_d = ST_FETCH;
      ST_FETCH: if (fetch_done_i) st_d = own_i ? ST_XFER : ST_SUSP;
      ST_XFER:  if (frame_done_i) st_d = start_i ? ST_FETCH : ST_STOP;
      ST_SUSP: begin
        if (!start_i)    st_d = ST_STOP;
        else if (poll_i) st_d = ST_FETCH;
      end
      default:  st_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_STOP;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/tdc_ptr.sv
module tdc_ptr #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DESC_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          load_i,
  input  logic          accept_i,
  input  logic          eor_i,
  input  logic          adv_i,
  input  logic          save_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  logic [AW-1:0] ptr_q;
  logic          saved_q;
  logic          eor_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      saved_q <= 1'b0;
      eor_q   <= 1'b0;
    end else begin
      // first start after reset takes the base; later starts resume
      if (load_i && !saved_q) ptr_q <= base_i;
      if (accept_i)           eor_q <= eor_i;
      if (adv_i)              ptr_q <= eor_q ? base_i : ptr_q + STEP;
      if (save_i)             saved_q <= 1'b1;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tdc_sts.sv
module tdc_sts (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  logic sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sts_q <= 1'b0;
    else if (set_i) sts_q <= 1'b1;  // set wins over clear
    else if (clr_i) sts_q <= 1'b0;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/tx_dma_ctrl.sv
module tx_dma_ctrl
  import tdc_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DESC_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          poll_i,
  input  logic [AW-1:0] list_base_i,
  input  logic          fetch_done_i,
  input  logic          own_i,
  input  logic          eor_i,
  input  logic          frame_done_i,
  input  logic          susp_clr_i,
  output logic [1:0]    state_o,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          susp_sts_o
);
  ctl_st_e st;
  logic    load, accept, miss, adv, save;

  tdc_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .poll_i       (poll_i),
    .fetch_done_i (fetch_done_i),
    .own_i        (own_i),
    .frame_done_i (frame_done_i),
    .st_o         (st),
    .load_o       (load),
    .accept_o     (accept),
    .miss_o       (miss),
    .adv_o        (adv),
    .save_o       (save)
  );

  tdc_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .base_i   (list_base_i),
    .load_i   (load),
    .accept_i (accept),
    .eor_i    (eor_i),
    .adv_i    (adv),
    .save_i   (save),
    .ptr_o    (fetch_addr_o)
  );

  tdc_sts u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (miss),
    .clr_i  (susp_clr_i),
    .sts_o  (susp_sts_o)
  );

  always_comb begin
    unique case (st)
      ST_STOP:  state_o = OUT_STOPPED;
      ST_SUSP:  state_o = OUT_SUSPEND;
      default:  state_o = OUT_RUNNING;
    endcase
  end

  assign fetch_req_o = (st == ST_FETCH);
endmodule

// File: rtl/tx_dma_ctrl_chk.sv
module tx_dma_ctrl_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          poll_i,
  input logic          fetch_done_i,
  input logic          own_i,
  input logic          frame_done_i,
  input logic          susp_clr_i,
  input logic [1:0]    state_o,
  input logic          fetch_req_o,
  input logic [AW-1:0] fetch_addr_o,
  input logic          susp_sts_o
);
  logic in_frame, suspending;
  assign in_frame   = (state_o == 2'd1) && !fetch_req_o;
  assign suspending = fetch_req_o && fetch_done_i && !own_i;

  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3); // R1

  AST_START_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0) && start_i |=> (state_o == 2'd1) && fetch_req_o); // R2

  AST_OWN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && fetch_done_i && own_i |=> (state_o == 2'd1) && !fetch_req_o); // R3

  AST_MISS_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspending |=> (state_o == 2'd2) && susp_sts_o); // R3

  AST_NO_EARLY_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_frame && !frame_done_i |=> (state_o == 2'd1) && $stable(fetch_addr_o)); // R5

  AST_SUSP_TO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) && !start_i |=> (state_o == 2'd0) && $stable(fetch_addr_o)); // R7

  AST_POLL_REFETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) && start_i && poll_i |=> fetch_req_o && $stable(fetch_addr_o)); // R8

  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_clr_i && !suspending |=> !susp_sts_o); // R9

  AST_POLL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_frame && poll_i && !frame_done_i |=> !fetch_req_o); // R10
endmodule

bind tx_dma_ctrl tx_dma_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .poll_i       (poll_i),
  .fetch_done_i (fetch_done_i),
  .own_i        (own_i),
  .frame_done_i (frame_done_i),
  .susp_clr_i   (susp_clr_i),
  .state_o      (state_o),
  .fetch_req_o  (fetch_req_o),
  .fetch_addr_o (fetch_addr_o),
  .susp_sts_o   (susp_sts_o)
);

// File: tb/tx_dma_ctrl_test.sv
module tx_dma_ctrl_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 0, poll_i = 0, fetch_done_i = 0, own_i = 0;
  logic          eor_i = 0, frame_done_i = 0, susp_clr_i = 0;
  logic [AW-1:0] list_base_i = 32'h1000;
  logic [1:0]    state_o;
  logic          fetch_req_o, susp_sts_o;
  logic [AW-1:0] fetch_addr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [1:0]  st;
    logic        req;
    logic [31:0] addr;
    logic        susp;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  tx_dma_ctrl #(.AW(AW), .DESC_BYTES(16)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .poll_i(poll_i),
    .list_base_i(list_base_i), .fetch_done_i(fetch_done_i), .own_i(own_i),
    .eor_i(eor_i), .frame_done_i(frame_done_i), .susp_clr_i(susp_clr_i),
    .state_o(state_o), .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .susp_sts_o(susp_sts_o)
  );

  // drive one cycle of inputs, queue the result expected after the next edge
  task automatic cyc(input logic st, input logic pl, input logic fd, input logic ow,
                     input logic er, input logic fr, input logic cl,
                     input logic [1:0] e_st, input logic e_req, input logic [31:0] e_addr,
                     input logic e_susp, input string tag);
    exp_t e;
    @(negedge clk);
    start_i = st; poll_i = pl; fetch_done_i = fd; own_i = ow;
    eor_i = er; frame_done_i = fr; susp_clr_i = cl;
    e.st = e_st; e.req = e_req; e.addr = e_addr; e.susp = e_susp; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (state_o !== e.st || fetch_req_o !== e.req ||
            fetch_addr_o !== e.addr || susp_sts_o !== e.susp) begin
          n_fail++;
          $display("FAIL %s: got st=%0d req=%0b addr=%h susp=%0b exp st=%0d req=%0b addr=%h susp=%0b",
                   e.tag, state_o, fetch_req_o, fetch_addr_o, susp_sts_o,
                   e.st, e.req, e.addr, e.susp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (state_o !== 2'd0 || fetch_req_o !== 1'b0 || susp_sts_o !== 1'b0 || fetch_addr_o !== '0) begin
      n_fail++;
      $display("FAIL R1: got st=%0d req=%0b susp=%0b addr=%h exp 0/0/0/0",
               state_o, fetch_req_o, susp_sts_o, fetch_addr_o);
    end
    rst_ni = 1'b1;
    //  st pl fd ow er fr cl   exp st req addr susp
    cyc(1, 0, 0, 0, 0, 0, 0, 2'd1, 1, 32'h1000, 0, "R2 start at base");
    cyc(1, 0, 1, 1, 0, 0, 0, 2'd1, 0, 32'h1000, 0, "R3 owned runs");
    cyc(1, 1, 0, 0, 0, 0, 0, 2'd1, 0, 32'h1000, 0, "R10 poll ignored");
    cyc(1, 0, 0, 0, 0, 1, 0, 2'd1, 1, 32'h1010, 0, "R4 advance");
    cyc(1, 0, 1, 1, 1, 0, 0, 2'd1, 0, 32'h1010, 0, "R3 owned eor desc");
    cyc(1, 0, 0, 0, 0, 1, 0, 2'd1, 1, 32'h1000, 0, "R4 wrap to base");
    cyc(1, 0, 1, 1, 0, 0, 0, 2'd1, 0, 32'h1000, 0, "R3 owned");
    cyc(0, 0, 0, 0, 0, 0, 0, 2'd1, 0, 32'h1000, 0, "R5 stop deferred");
    cyc(0, 0, 0, 0, 0, 1, 0, 2'd0, 0, 32'h1010, 0, "R5 stop at frame end");
    @(negedge clk); list_base_i = 32'h2000;
    cyc(1, 0, 0, 0, 0, 0, 0, 2'd1, 1, 32'h1010, 0, "R6 resume saved");
    cyc(1, 0, 1, 0, 0, 0, 0, 2'd2, 0, 32'h1010, 1, "R3 unowned suspends");
    cyc(1, 1, 0, 0, 0, 0, 0, 2'd1, 1, 32'h1010, 1, "R8 poll refetch");
    cyc(1, 0, 1, 0, 0, 0, 0, 2'd2, 0, 32'h1010, 1, "R3 unowned again");
    cyc(1, 0, 0, 0, 0, 0, 1, 2'd2, 0, 32'h1010, 0, "R9 w1c clears");
    cyc(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 32'h1010, 0, "R7 stop from suspend");
    cyc(1, 0, 0, 0, 0, 0, 0, 2'd1, 1, 32'h1010, 0, "R7 restart same desc");
    cyc(1, 0, 1, 0, 0, 0, 0, 2'd2, 0, 32'h1010, 1, "R3 suspend");
    cyc(1, 1, 0, 0, 0, 0, 0, 2'd1, 1, 32'h1010, 1, "R8 poll");
    cyc(1, 0, 1, 0, 0, 0, 1, 2'd2, 0, 32'h1010, 1, "R9 set beats clear");
    cyc(1, 1, 0, 0, 0, 0, 0, 2'd1, 1, 32'h1010, 1, "R8 poll");
    cyc(1, 0, 1, 1, 0, 0, 0, 2'd1, 0, 32'h1010, 1, "R8 owned resumes");
    cyc(1, 0, 0, 0, 0, 1, 0, 2'd1, 1, 32'h1020, 1, "R4 advance after resume");
    cyc(1, 0, 0, 0, 0, 0, 0, 2'd1, 1, 32'h1020, 1, "R3 fetch pending holds");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      begin
        repeat (2000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
      end
      wait (done);
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule